// File: doc/BRIEF.md
# Serial Audio Bit and Frame Clock Generator

This block produces the bit clock and the left/right frame clock of a stereo serial audio port. It runs from the master audio clock, which is its only clock. In drive mode it divides the master clock down to the bit clock and counts bit clocks to build frames. In follow mode it takes both clocks from an external codec, resynchronises them and detects their edges. In either mode the serializers get single-cycle strobes that mark the sampling edge, the shifting edge and the start of each frame.

The divide ratio is 2 or 4, and a frame is 32, 64 or 128 bit clocks long. Both can be set by hand, or an automatic helper can choose them from a supplied count of master clocks per sample. Polarity controls invert the bit clock and swap which half of the frame the frame clock is low in. A global enable starts and stops the clocks. While the port is enabled, a change to divide, length or polarity waits for the next frame start before it takes effect.

Top module: `audclk_gen`

## Requirements
- R1: In drive mode each bit clock lasts `div_sel`=0: 2 master cycles, `div_sel`=1: 4 master cycles, so a frame lasts divide × frame-length master cycles.
- R2: `frame_sel` sets the frame length: 00 gives 32 bit clocks, 01 gives 64, and 10 or 11 gives 128. Each frame holds exactly that many `shift_stb` pulses.
- R3: `right_word` is 0 for the first half of each frame and 1 for the second half (50% duty). In drive mode it changes only in a cycle that carries `shift_stb`.
- R4: With `auto_sel`=1, `div_sel` and `frame_sel` are ignored and the setting is chosen from `ratio_in` as follows:
  - above 384: 128 bits and divide by 4;
  - from 192 to 384: 64 bits and divide by 4;
  - below 192: 64 bits and divide by 2.
- R5: With `bclk_inv`=0, `bclk_o` is 1 in a cycle that carries `sample_stb` and 0 in a cycle that carries `shift_stb`. With `bclk_inv`=1 both levels are inverted.
- R6: In drive mode, `lrclk_o` equals `right_word` when `lr_inv`=0, so the frame clock is low during the left word. It equals the inverse of `right_word` when `lr_inv`=1, so the frame clock is low during the right word.
- R7: `master_sel` is taken only while `enable` is 0.
  - With `master_sel`=1 (drive mode), `clk_oe` is 1 and the block drives `bclk_o` and `lrclk_o`.
  - With `master_sel`=0 (follow mode), `clk_oe` is 0 and `bclk_o` and `lrclk_o` are 0. The strobes then come from the external clocks after a two-flop synchronizer:
    - `sample_stb` marks a rise of the internal bit clock;
    - `shift_stb` marks a fall of the internal bit clock;
    - `frame_stb` marks a right-to-left change of the frame clock.
- R8: When `enable` is 0, no strobe is produced and the drive-mode clocks hold still, with the internal bit clock high and `right_word`=1. In drive mode with divide 2, the first active edge after `enable` rises starts a frame.
- R9: `sample_stb` and `shift_stb` are single-cycle pulses and never occur together. A frame holds as many `sample_stb` pulses as bits. In drive mode `frame_stb` occurs only together with `shift_stb`.
- R10: While enabled, a change to divide, frame length or polarity waits for the next frame start, so the current frame finishes with the old setting.
- R11: During and just after reset, all strobes, `clk_oe`, `bclk_o` and `lrclk_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global clock enable |
| master_sel | input | 1 | 1: drive the clocks, 0: follow external clocks |
| auto_sel | input | 1 | 1: choose divide and length from `ratio_in` |
| ratio_in | input | RATIO_W | Master clocks per sample, for the automatic choice |
| div_sel | input | 1 | Manual divide: 0 = 2, 1 = 4 |
| frame_sel | input | 2 | Manual frame length: 00 = 32, 01 = 64, 1x = 128 |
| bclk_inv | input | 1 | Bit clock polarity |
| lr_inv | input | 1 | Frame clock polarity |
| ext_bclk_i | input | 1 | External bit clock (follow mode) |
| ext_lrclk_i | input | 1 | External frame clock (follow mode) |
| bclk_o | output | 1 | Generated bit clock |
| lrclk_o | output | 1 | Generated frame clock |
| clk_oe | output | 1 | Output enable for the clock pins |
| right_word | output | 1 | 1 while the right word is in progress |
| sample_stb | output | 1 | Sampling-edge strobe |
| shift_stb | output | 1 | Shifting-edge strobe |
| frame_stb | output | 1 | Frame-start strobe |

## Verification
The bench uses the default parameters:
- a 32-bit base frame, so the lengths are 32, 64 and 128;
- thresholds at 384 and 192 on a 12-bit ratio;
- a two-stage synchronizer.

With these values every frame length and both divide ratios can be measured in a few hundred master cycles. The ratios 191, 192, 384 and 385 sit exactly on the automatic-choice boundaries. The short frames let a mid-frame change to the frame length be seen finishing one frame at the old length and running the next at the new length. A follow-mode run of two frames covers the synchronizer and the edge detectors.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  typedef struct packed {
    logic       master;
    logic       div4;
    logic [1:0] flen;
    logic       bclk_inv;
    logic       lr_inv;
  } cfg_t;

  // Length code: 0 -> base, 1 -> 2x base, 2 -> 4x base; code 3 folds onto 2.
  function automatic logic [1:0] flen_of(input logic [1:0] sel);
    return sel[1] ? 2'd2 : sel;
  endfunction

endpackage

// File: rtl/audclk_ratio_pick.sv
module audclk_ratio_pick #(
  parameter int RATIO_W = 12,
  parameter int HI_THR  = 384,
  parameter int LO_THR  = 192
) (
  input  logic [RATIO_W-1:0] ratio,
  output logic               div4,
  output logic [1:0]         flen
);
  localparam logic [RATIO_W-1:0] HI = RATIO_W'(HI_THR);
  localparam logic [RATIO_W-1:0] LO = RATIO_W'(LO_THR);

  always_comb begin
    if (ratio > HI) begin
      div4 = 1'b1;
      flen = 2'd2;
    end else begin
      flen = 2'd1;
      div4 = (ratio >= LO);
    end
  end
endmodule

// File: rtl/audclk_sync.sv
module audclk_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= '0;
      else        st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/audclk_mtmg.sv
module audclk_mtmg #(
  parameter int FL_BASE  = 32,
  parameter int FL_CODES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       div4,
  input  logic [1:0] flen,
  output logic       b_o,
  output logic       right_o,
  output logic       sample_o,
  output logic       shift_o,
  output logic       frame_o,
  output logic       wrap_o
);
  localparam int NB_MAX = FL_BASE << (FL_CODES - 1);
  localparam int BITC_W = $clog2(NB_MAX);
  localparam int NB_W   = BITC_W + 1;

  logic [NB_W-1:0]   nbits, last, half;
  logic              ph_q, ph_d;
  logic              b_q, b_d;
  logic              r_q, r_d;
  logic [BITC_W-1:0] bc_q, bc_d;
  logic              sa_d, sh_d, fr_d;
  logic              sa_q, sh_q, fr_q;

  assign nbits = NB_W'(FL_BASE) << flen;
  assign last  = nbits - NB_W'(1);
  assign half  = nbits >> 1;

  always_comb begin
    ph_d = ph_q;
    b_d  = b_q;
    r_d  = r_q;
    bc_d = bc_q;
    sa_d = 1'b0;
    sh_d = 1'b0;
    fr_d = 1'b0;
    if (!run) begin
      ph_d = 1'b0;
      b_d  = 1'b1;
      r_d  = 1'b1;
      bc_d = '1;
    end else if (ph_q == div4) begin
      ph_d = 1'b0;
      b_d  = ~b_q;
      if (b_q) begin
        sh_d = 1'b1;
        if ({1'b0, bc_q} >= last) begin
          bc_d = '0;
          fr_d = 1'b1;
        end else begin
          bc_d = bc_q + BITC_W'(1);
        end
        r_d = ({1'b0, bc_d} >= half);
      end else begin
        sa_d = 1'b1;
      end
    end else begin
      ph_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 1'b0;
      b_q  <= 1'b1;
      r_q  <= 1'b1;
      bc_q <= '1;
      sa_q <= 1'b0;
      sh_q <= 1'b0;
      fr_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      b_q  <= b_d;
      r_q  <= r_d;
      bc_q <= bc_d;
      sa_q <= sa_d;
      sh_q <= sh_d;
      fr_q <= fr_d;
    end
  end

  assign b_o      = b_q;
  assign right_o  = r_q;
  assign sample_o = sa_q;
  assign shift_o  = sh_q;
  assign frame_o  = fr_q;
  assign wrap_o   = fr_d;
endmodule

// File: rtl/audclk_slv.sv
module audclk_slv #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ext_bclk,
  input  logic ext_lr,
  input  logic bclk_inv,
  input  logic lr_inv,
  output logic right_o,
  output logic sample_o,
  output logic shift_o,
  output logic frame_o,
  output logic wrap_o
);
  logic [1:0] sy;
  logic       b_i, r_i;
  logic       b_p, r_p;
  logic       sa_d, sh_d, fr_d;
  logic       sa_q, sh_q, fr_q, rq;

  audclk_sync #(.W(2), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ext_lr, ext_bclk}),
    .q     (sy)
  );

  assign b_i = sy[0] ^ bclk_inv;
  assign r_i = sy[1] ^ lr_inv;

  always_comb begin
    sa_d = run &  b_i & ~b_p;
    sh_d = run & ~b_i &  b_p;
    fr_d = run & ~r_i &  r_p;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_p  <= 1'b0;
      r_p  <= 1'b0;
      sa_q <= 1'b0;
      sh_q <= 1'b0;
      fr_q <= 1'b0;
      rq   <= 1'b0;
    end else begin
      b_p  <= b_i;
      r_p  <= r_i;
      sa_q <= sa_d;
      sh_q <= sh_d;
      fr_q <= fr_d;
      rq   <= r_i;
    end
  end

  assign right_o  = rq;
  assign sample_o = sa_q;
  assign shift_o  = sh_q;
  assign frame_o  = fr_q;
  assign wrap_o   = fr_d;
endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
  import audclk_pkg::*;
#(
  parameter int RATIO_W  = 12,
  parameter int HI_THR   = 384,
  parameter int LO_THR   = 192,
  parameter int FL_BASE  = 32,
  parameter int FL_CODES = 3,
  parameter int SYNC_STG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               master_sel,
  input  logic               auto_sel,
  input  logic [RATIO_W-1:0] ratio_in,
  input  logic               div_sel,
  input  logic [1:0]         frame_sel,
  input  logic               bclk_inv,
  input  logic               lr_inv,
  input  logic               ext_bclk_i,
  input  logic               ext_lrclk_i,
  output logic               bclk_o,
  output logic               lrclk_o,
  output logic               clk_oe,
  output logic               right_word,
  output logic               sample_stb,
  output logic               shift_stb,
  output logic               frame_stb
);
  cfg_t       cfg_in, cfg_d, cfg_q;
  logic       pk_div4;
  logic [1:0] pk_flen;
  logic       m_run, s_run;
  logic       m_b, m_r, m_sa, m_sh, m_fr, m_wrap;
  logic       s_r, s_sa, s_sh, s_fr, s_wrap;
  logic       wrap;

  audclk_ratio_pick #(.RATIO_W(RATIO_W), .HI_THR(HI_THR), .LO_THR(LO_THR)) u_pick (
    .ratio (ratio_in),
    .div4  (pk_div4),
    .flen  (pk_flen)
  );

  always_comb begin
    cfg_in.master   = master_sel;
    cfg_in.div4     = auto_sel ? pk_div4 : div_sel;
    cfg_in.flen     = auto_sel ? pk_flen : flen_of(frame_sel);
    cfg_in.bclk_inv = bclk_inv;
    cfg_in.lr_inv   = lr_inv;
  end

  assign wrap = cfg_q.master ? m_wrap : s_wrap;

  always_comb begin
    cfg_d = cfg_q;
    if (!enable) begin
      cfg_d = cfg_in;
    end else if (wrap) begin
      cfg_d        = cfg_in;
      cfg_d.master = cfg_q.master;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign m_run = enable &  cfg_q.master;
  assign s_run = enable & ~cfg_q.master;

  audclk_mtmg #(.FL_BASE(FL_BASE), .FL_CODES(FL_CODES)) u_mtmg (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (m_run),
    .div4     (cfg_q.div4),
    .flen     (cfg_q.flen),
    .b_o      (m_b),
    .right_o  (m_r),
    .sample_o (m_sa),
    .shift_o  (m_sh),
    .frame_o  (m_fr),
    .wrap_o   (m_wrap)
  );

  audclk_slv #(.STAGES(SYNC_STG)) u_slv (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (s_run),
    .ext_bclk (ext_bclk_i),
    .ext_lr   (ext_lrclk_i),
    .bclk_inv (cfg_q.bclk_inv),
    .lr_inv   (cfg_q.lr_inv),
    .right_o  (s_r),
    .sample_o (s_sa),
    .shift_o  (s_sh),
    .frame_o  (s_fr),
    .wrap_o   (s_wrap)
  );

  always_comb begin
    clk_oe = cfg_q.master;
    if (cfg_q.master) begin
      bclk_o     = m_b ^ cfg_q.bclk_inv;
      lrclk_o    = m_r ^ cfg_q.lr_inv;
      right_word = m_r;
      sample_stb = m_sa;
      shift_stb  = m_sh;
      frame_stb  = m_fr;
    end else begin
      bclk_o     = 1'b0;
      lrclk_o    = 1'b0;
      right_word = s_r;
      sample_stb = s_sa;
      shift_stb  = s_sh;
      frame_stb  = s_fr;
    end
  end
endmodule

// File: rtl/audclk_gen_chk.sv
module audclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic clk_oe,
  input logic right_word,
  input logic sample_stb,
  input logic shift_stb,
  input logic frame_stb
);
  // R9: the two edge strobes never coincide
  a_r9_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && shift_stb));

  // R9: in drive mode a frame starts on a shifting edge
  a_r9_frame_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_oe && frame_stb) |-> shift_stb);

  // R8: a low enable silences every strobe on the next cycle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sample_stb && !shift_stb && !frame_stb));

  // R7: the drive/follow choice moves only while disabled
  a_r7_mode_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_oe != $past(clk_oe)) |-> !$past(enable));

  // R3: in drive mode the word flag changes only on a shifting edge
  a_r3_word_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_oe && $past(clk_oe) && $past(enable) && (right_word != $past(right_word))) |-> shift_stb);
endmodule

bind audclk_gen audclk_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .clk_oe     (clk_oe),
  .right_word (right_word),
  .sample_stb (sample_stb),
  .shift_stb  (shift_stb),
  .frame_stb  (frame_stb)
);

// File: tb/audclk_gen_tb_top.sv
`timescale 1ns/1ps
module audclk_gen_tb_top;
  logic        clk, rst_n;
  logic        enable, master_sel, auto_sel, div_sel, bclk_inv, lr_inv;
  logic [11:0] ratio_in;
  logic [1:0]  frame_sel;
  logic        ext_bclk_i, ext_lrclk_i;
  logic        bclk_o, lrclk_o, clk_oe, right_word, sample_stb, shift_stb, frame_stb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cnt_en = 0;
  int c_sa = 0, c_sh = 0, c_fr = 0;

  audclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .master_sel(master_sel),
    .auto_sel(auto_sel), .ratio_in(ratio_in), .div_sel(div_sel),
    .frame_sel(frame_sel), .bclk_inv(bclk_inv), .lr_inv(lr_inv),
    .ext_bclk_i(ext_bclk_i), .ext_lrclk_i(ext_lrclk_i),
    .bclk_o(bclk_o), .lrclk_o(lrclk_o), .clk_oe(clk_oe),
    .right_word(right_word), .sample_stb(sample_stb),
    .shift_stb(shift_stb), .frame_stb(frame_stb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cnt_en) begin
      c_sa = c_sa + int'(sample_stb);
      c_sh = c_sh + int'(shift_stb);
      c_fr = c_fr + int'(frame_stb);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setup(input bit m, input bit a, input int r, input bit d, input logic [1:0] f,
                       input bit bi, input bit li, input bit start);
    @(negedge clk);
    enable = 1'b0;
    master_sel = m; auto_sel = a; ratio_in = 12'(r); div_sel = d;
    frame_sel = f; bclk_inv = bi; lr_inv = li;
    repeat (4) @(negedge clk);
    if (start) enable = 1'b1;
  endtask

  task automatic wait_frame(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (frame_stb) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  // Called in a cycle that carries frame_stb; measures the frame that starts here.
  task automatic measure_here(input int exp_per, input int exp_bits, input string req, input bit bi, input bit li);
    int per = 0, sh = 0, sa = 0, rh = 0, bad_lr = 0, bad_b = 0;
    int first_r;
    first_r = int'(right_word);
    do begin
      per++;
      sh += int'(shift_stb);
      sa += int'(sample_stb);
      rh += int'(right_word);
      if (lrclk_o != (right_word ^ li)) bad_lr++;
      if (sample_stb && (bclk_o != !bi)) bad_b++;
      if (shift_stb && (bclk_o != bi)) bad_b++;
      @(negedge clk);
    end while (!frame_stb && per < 5000);
    chk(per == exp_per, req, "frame period", per, exp_per);
    chk(sh == exp_bits, req, "shift strobes per frame", sh, exp_bits);
    chk(sa == exp_bits, "R9", "sample strobes per frame", sa, exp_bits);
    chk(rh == exp_per / 2, "R3", "right-word cycles", rh, exp_per / 2);
    chk(first_r == 0, "R3", "left word at frame start", first_r, 0);
    chk(bad_lr == 0, "R6", "frame clock polarity mismatches", bad_lr, 0);
    chk(bad_b == 0, "R5", "bit clock level mismatches", bad_b, 0);
  endtask

  task automatic measure(input int exp_per, input int exp_bits, input string req, input bit bi, input bit li);
    bit ok;
    wait_frame(ok);
    chk(ok, req, "frame start seen", int'(ok), 1);
    if (ok) measure_here(exp_per, exp_bits, req, bi, li);
  endtask

  task automatic t_reset;
    chk(!sample_stb && !shift_stb && !frame_stb, "R11", "strobes in reset",
        int'({sample_stb, shift_stb, frame_stb}), 0);
    chk(!clk_oe && !bclk_o && !lrclk_o, "R11", "clock outputs in reset",
        int'({clk_oe, bclk_o, lrclk_o}), 0);
  endtask

  task automatic t_manual;
    setup(1, 0, 0, 0, 2'b00, 0, 0, 1); measure(64, 32, "R1", 0, 0);
    setup(1, 0, 0, 1, 2'b01, 0, 0, 1); measure(256, 64, "R2", 0, 0);
    setup(1, 0, 0, 0, 2'b10, 0, 1, 1); measure(256, 128, "R2", 0, 1);
    setup(1, 0, 0, 1, 2'b11, 1, 0, 1); measure(512, 128, "R2", 1, 0);
    setup(1, 0, 0, 1, 2'b00, 1, 1, 1); measure(128, 32, "R1", 1, 1);
  endtask

  task automatic t_auto;
    setup(1, 1, 191, 1, 2'b11, 0, 0, 1); measure(128, 64, "R4", 0, 0);
    setup(1, 1, 192, 0, 2'b00, 0, 0, 1); measure(256, 64, "R4", 0, 0);
    setup(1, 1, 384, 0, 2'b11, 0, 0, 1); measure(256, 64, "R4", 0, 0);
    setup(1, 1, 385, 0, 2'b00, 0, 0, 1); measure(512, 128, "R4", 0, 0);
  endtask

  task automatic t_start_stop;
    int quiet = 0, moved = 0;
    setup(1, 0, 0, 0, 2'b00, 0, 0, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (sample_stb || shift_stb || frame_stb) quiet++;
    end
    chk(quiet == 0, "R8", "strobes while disabled", quiet, 0);
    chk(clk_oe == 1'b1, "R7", "drive mode output enable", int'(clk_oe), 1);
    chk(bclk_o == 1'b1, "R8", "idle bit clock level", int'(bclk_o), 1);
    enable = 1'b1;
    @(negedge clk);
    chk(frame_stb && shift_stb, "R8", "frame starts on first edge", int'({frame_stb, shift_stb}), 3);
    repeat (40) @(negedge clk);
    enable = 1'b0;
    quiet = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sample_stb || shift_stb || frame_stb) quiet++;
      if (bclk_o != 1'b1 || right_word != 1'b1 || lrclk_o != 1'b1) moved++;
    end
    chk(quiet == 0, "R8", "strobes after disable", quiet, 0);
    chk(moved == 0, "R8", "clocks held after disable", moved, 0);
  endtask

  task automatic t_boundary;
    bit ok;
    int per = 0;
    setup(1, 0, 0, 0, 2'b00, 0, 0, 1);
    wait_frame(ok);
    frame_sel = 2'b01;
    do begin
      per++;
      @(negedge clk);
    end while (!frame_stb && per < 5000);
    chk(per == 64, "R10", "current frame keeps old length", per, 64);
    measure_here(128, 64, "R10", 0, 0);
  endtask

  task automatic drive_ext(input int nframes, input int nbits);
    for (int f = 0; f < nframes; f++) begin
      for (int k = 0; k < nbits; k++) begin
        ext_bclk_i = 1'b0;
        if (k == 0) ext_lrclk_i = 1'b0;
        if (k == nbits / 2) ext_lrclk_i = 1'b1;
        repeat (4) @(negedge clk);
        ext_bclk_i = 1'b1;
        repeat (4) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic t_follow;
    ext_bclk_i = 1'b1;
    ext_lrclk_i = 1'b1;
    setup(0, 0, 0, 0, 2'b00, 0, 0, 1);
    c_sa = 0; c_sh = 0; c_fr = 0;
    cnt_en = 1'b1;
    drive_ext(2, 32);
    cnt_en = 1'b0;
    chk(c_sh == 64, "R7", "follow-mode shift strobes", c_sh, 64);
    chk(c_sa == 64, "R7", "follow-mode sample strobes", c_sa, 64);
    chk(c_fr == 2, "R7", "follow-mode frame strobes", c_fr, 2);
    chk(!clk_oe && !bclk_o && !lrclk_o, "R7", "follow mode does not drive",
        int'({clk_oe, bclk_o, lrclk_o}), 0);
    chk(right_word == 1'b1, "R7", "follow-mode word flag", int'(right_word), 1);
    enable = 1'b0;
    c_sa = 0; c_sh = 0; c_fr = 0;
    cnt_en = 1'b1;
    drive_ext(1, 32);
    cnt_en = 1'b0;
    chk(c_sa + c_sh + c_fr == 0, "R8", "follow-mode strobes while disabled", c_sa + c_sh + c_fr, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    enable = 1'b0; master_sel = 1'b0; auto_sel = 1'b0; ratio_in = '0;
    div_sel = 1'b0; frame_sel = 2'b00; bclk_inv = 1'b0; lr_inv = 1'b0;
    ext_bclk_i = 1'b0; ext_lrclk_i = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_manual;
    t_auto;
    t_start_stop;
    t_boundary;
    t_follow;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule